// File: doc/BRIEF.md
# Two-Colour Bar Pattern Source

This block sits at the end of a display pipe and, when switched on, replaces the outgoing pixel stream with stripes that alternate between two programmable RGB colours. The stripes run either vertically (the colour flips as the horizontal counter advances) or horizontally (the colour flips as the vertical counter advances), with the stripe size a power of two picked per axis. The raster position and the active-area flag come from the timing logic upstream. The block adds one register stage.

The two colours are six 16-bit components held in a small palette that is loaded through one port carrying a one-hot component mask and a data word. The port is pipelined: the data word of a write goes to the component named by the mask of the write before it. A full load is therefore seven writes, the first carrying only a mask and the last repeating the final mask. Component values are left-aligned. The ten upper bits are kept, the six lower bits always read as zero, and a depth setting trims the output further to 6, 8 or 10 significant bits.

Top module: `bar_pattern_gen`

## Requirements
- R1: After reset the output is zero, the pattern is off, the depth setting is 8 bits, both stripe sizes are 1, colour 0 is white (every component all ones in its kept bits) and colour 1 is black.
- R2: A colour write stores its data into each component whose bit was set in the mask of the previous colour write; the first colour write after reset stores nothing, and without a colour write the palette holds.
- R3: Mask bit 0 selects red of colour 0, bit 1 green of colour 0, bit 2 blue of colour 0, bit 3 red of colour 1, bit 4 green of colour 1, bit 5 blue of colour 1.
- R4: Only bits 15..6 of the written data are stored; bits 5..0 of every pattern component are zero.
- R5: ctrl_data[3:2] sets the depth: 0 keeps the top 6 bits of each component, 1 the top 8, 2 the top 10, 3 behaves as 1; the lower bits of pattern output components are zero.
- R6: With ctrl_data[1]=0 (vertical stripes) colour 0 is shown where bit HRES of hcount is 0 and colour 1 where it is 1, HRES being ctrl_data[7:4].
- R7: With ctrl_data[1]=1 (horizontal stripes) colour 0 is shown where bit VRES of vcount is 0 and colour 1 where it is 1, VRES being ctrl_data[11:8].
- R8: When active is low the output is zero, whether the pattern is on or off.
- R9: With ctrl_data[0]=0 (pattern off) and active high, video_in passes to the output unchanged.
- R10: The output reflects the inputs of the previous clock edge; a control write takes effect on pixels presented after that write.
- R11: A stripe size exponent of CNT_W or more selects colour 0 for every pixel.
- R12: pix_out packs red in bits 47..32, green in 31..16 and blue in 15..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_data | input | 12 | {VRES, HRES, depth, horizontal, enable} |
| col_we | input | 1 | Colour register write strobe |
| col_mask | input | 6 | One-hot component mask for the next write |
| col_data | input | 16 | Left-aligned component data for the previous mask |
| hcount | input | CNT_W | Horizontal raster position |
| vcount | input | CNT_W | Vertical raster position |
| active | input | 1 | Raster is inside the active area |
| video_in | input | 48 | Normal pixel stream |
| pix_out | output | 48 | Registered RGB output pixel |

## Verification
Stripe selection is swept over every horizontal and vertical position in a small window for several stripe exponents in both orientations, which separates an off-by-one bit choice and a swapped axis from correct behaviour. The palette is loaded with six distinct component values through the seven-write sequence, so a mask that takes effect one write early or late, or a misordered component, shows up as a wrong colour channel. Each depth setting is applied to data with every bit set, telling the kept bit counts apart, and blanking, pass-through and the out-of-range exponent are each probed with a non-zero video stream.

// File: rtl/bar_pkg.sv
package bar_pkg;

  localparam int COMP_W   = 16;
  localparam int NUM_COMP = 6;
  localparam int PIX_W    = 3 * COMP_W;
  localparam int CTRL_W   = 12;

  typedef enum logic [1:0] {
    DEPTH_6   = 2'd0,
    DEPTH_8   = 2'd1,
    DEPTH_10  = 2'd2,
    DEPTH_RSV = 2'd3
  } depth_e;

  typedef struct packed {
    logic [3:0] vres;
    logic [3:0] hres;
    depth_e     depth;
    logic       horiz;
    logic       en;
  } cfg_t;

  // Bits of a component that survive a given depth setting
  function automatic logic [COMP_W-1:0] depth_keep(depth_e d);
    case (d)
      DEPTH_6:  depth_keep = 16'hFC00;
      DEPTH_10: depth_keep = 16'hFFC0;
      default:  depth_keep = 16'hFF00;
    endcase
  endfunction

  // Stripe phase: selected counter bit, zero when the exponent is out of range
  function automatic logic stripe_phase(logic [15:0] cnt, logic [3:0] idx, int cnt_w);
    if (int'(idx) >= cnt_w) stripe_phase = 1'b0;
    else                    stripe_phase = cnt[idx];
  endfunction

endpackage

// File: rtl/bar_cfg_regs.sv
module bar_cfg_regs
  import bar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_data,
  output cfg_t              cfg
);

  localparam cfg_t CFG_RST = '{vres: 4'd0, hres: 4'd0, depth: DEPTH_8,
                               horiz: 1'b0, en: 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg <= CFG_RST;
    else if (ctrl_we) cfg <= cfg_t'(ctrl_data);
  end

endmodule

// File: rtl/bar_palette.sv
module bar_palette
  import bar_pkg::*;
#(
  parameter int KEEP_W = 10
)(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             col_we,
  input  logic [NUM_COMP-1:0]              col_mask,
  input  logic [COMP_W-1:0]                col_data,
  output logic [NUM_COMP-1:0]              pend_mask,
  output logic [NUM_COMP-1:0][COMP_W-1:0]  comp
);

  localparam int ZERO_W = COMP_W - KEEP_W;

  // Mask latched on one write steers the data of the next
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_mask <= '0;
    else if (col_we) pend_mask <= col_mask;
  end

  for (genvar g = 0; g < NUM_COMP; g++) begin : g_comp
    localparam logic RST_ONE = (g < NUM_COMP / 2);
    logic [KEEP_W-1:0] keep_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     keep_q <= {KEEP_W{RST_ONE}};
      else if (col_we && pend_mask[g]) keep_q <= col_data[COMP_W-1 -: KEEP_W];
    end

    assign comp[g] = {keep_q, {ZERO_W{1'b0}}};
  end

endmodule

// File: rtl/bar_phase_sel.sv
module bar_phase_sel
  import bar_pkg::*;
#(
  parameter int CNT_W = 12
)(
  input  cfg_t             cfg,
  input  logic [CNT_W-1:0] hcount,
  input  logic [CNT_W-1:0] vcount,
  output logic             phase
);

  logic ph_v, ph_h;

  always_comb begin
    ph_v  = stripe_phase(16'(hcount), cfg.hres, CNT_W);
    ph_h  = stripe_phase(16'(vcount), cfg.vres, CNT_W);
    phase = cfg.horiz ? ph_h : ph_v;
  end

endmodule

// File: rtl/bar_pattern_gen.sv
module bar_pattern_gen
  import bar_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int KEEP_W = 10
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [11:0]       ctrl_data,
  input  logic              col_we,
  input  logic [5:0]        col_mask,
  input  logic [15:0]       col_data,
  input  logic [CNT_W-1:0]  hcount,
  input  logic [CNT_W-1:0]  vcount,
  input  logic              active,
  input  logic [47:0]       video_in,
  output logic [47:0]       pix_out
);

  localparam int HALF = NUM_COMP / 2;

  cfg_t                            cfg_q;
  logic [NUM_COMP-1:0]             pend_mask;
  logic [NUM_COMP-1:0][COMP_W-1:0] comp;
  logic                            phase;
  logic                            pat_en;
  depth_e                          pat_depth;
  logic [COMP_W-1:0]               keep;
  logic [PIX_W-1:0]                bar_pix;
  logic [PIX_W-1:0]                pix_d;

  bar_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_we),
    .ctrl_data (ctrl_data),
    .cfg       (cfg_q)
  );

  bar_palette #(.KEEP_W(KEEP_W)) u_pal (
    .clk       (clk),
    .rst_n     (rst_n),
    .col_we    (col_we),
    .col_mask  (col_mask),
    .col_data  (col_data),
    .pend_mask (pend_mask),
    .comp      (comp)
  );

  bar_phase_sel #(.CNT_W(CNT_W)) u_phase (
    .cfg    (cfg_q),
    .hcount (hcount),
    .vcount (vcount),
    .phase  (phase)
  );

  assign pat_en    = cfg_q.en;
  assign pat_depth = cfg_q.depth;
  assign keep      = depth_keep(cfg_q.depth);

  always_comb begin
    for (int c = 0; c < 3; c++) begin
      bar_pix[PIX_W-1-c*COMP_W -: COMP_W] =
        (phase ? comp[HALF + c] : comp[c]) & keep;
    end
    if (!active)     pix_d = '0;
    else if (pat_en) pix_d = bar_pix;
    else             pix_d = video_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_out <= '0;
    else        pix_out <= pix_d;
  end

endmodule

// File: rtl/bar_pattern_gen_chk.sv
module bar_pattern_gen_chk
  import bar_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     active,
  input logic [47:0]              video_in,
  input logic [47:0]              pix_out,
  input logic                     col_we,
  input logic [5:0]               col_mask,
  input logic [5:0]               pend_mask,
  input logic [NUM_COMP*COMP_W-1:0] comp_flat,
  input logic                     pat_en,
  input depth_e                   pat_depth
);

  a_r8_blank_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> pix_out == '0);

  a_r9_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !pat_en) |=> pix_out == $past(video_in));

  a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pat_en) |=> (pix_out[37:32] == '0 && pix_out[21:16] == '0 && pix_out[5:0] == '0));

  a_r5_six_bit_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pat_en && pat_depth == DEPTH_6) |=>
      (pix_out[41:32] == '0 && pix_out[25:16] == '0 && pix_out[9:0] == '0));

  a_r2_mask_pipelined: assert property (@(posedge clk) disable iff (!rst_n)
    col_we |=> pend_mask == $past(col_mask));

  a_r2_palette_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !col_we |=> $stable(comp_flat));

  a_r2_no_target_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (col_we && pend_mask == '0) |=> $stable(comp_flat));

endmodule

bind bar_pattern_gen bar_pattern_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .active    (active),
  .video_in  (video_in),
  .pix_out   (pix_out),
  .col_we    (col_we),
  .col_mask  (col_mask),
  .pend_mask (pend_mask),
  .comp_flat (comp),
  .pat_en    (pat_en),
  .pat_depth (pat_depth)
);

// File: tb/bar_pattern_gen_test.sv
module bar_pattern_gen_test;

  localparam int PERIOD = 10;
  localparam int CW     = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctrl_we = 1'b0;
  logic [11:0]   ctrl_data = '0;
  logic          col_we = 1'b0;
  logic [5:0]    col_mask = '0;
  logic [15:0]   col_data = '0;
  logic [CW-1:0] hcount = '0;
  logic [CW-1:0] vcount = '0;
  logic          active = 1'b0;
  logic [47:0]   video_in = '0;
  logic [47:0]   pix_out;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // bench model of the programmed state
  logic [15:0] m_comp [6];
  logic [5:0]  m_pend;
  bit          m_en, m_horiz;
  int          m_depth, m_hres, m_vres;

  bar_pattern_gen #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_data(ctrl_data),
    .col_we(col_we), .col_mask(col_mask), .col_data(col_data),
    .hcount(hcount), .vcount(vcount), .active(active),
    .video_in(video_in), .pix_out(pix_out)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [47:0] got, logic [47:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%012h exp=%012h", req, got, exp);
    end
  endtask

  task automatic set_ctrl(bit en, bit horiz, int depth, int hres, int vres);
    @(negedge clk);
    ctrl_we = 1'b1;
    ctrl_data = {vres[3:0], hres[3:0], depth[1:0], horiz, en};
    @(negedge clk);
    ctrl_we = 1'b0;
    m_en = en; m_horiz = horiz; m_depth = depth; m_hres = hres; m_vres = vres;
  endtask

  task automatic put_col(logic [5:0] mask, logic [15:0] data);
    @(negedge clk);
    col_we = 1'b1; col_mask = mask; col_data = data;
    @(negedge clk);
    col_we = 1'b0;
    for (int i = 0; i < 6; i++) if (m_pend[i]) m_comp[i] = data & 16'hFFC0;
    m_pend = mask;
  endtask

  function automatic logic [47:0] expect_pix(int h, int v, bit act, logic [47:0] vid);
    int keep, idx, cnt;
    logic [15:0] km;
    bit ph;
    if (!act) return '0;
    if (!m_en) return vid;
    keep = (m_depth == 0) ? 6 : (m_depth == 2) ? 10 : 8;
    km = 16'hFFFF << (16 - keep);
    idx = m_horiz ? m_vres : m_hres;
    cnt = m_horiz ? v : h;
    ph = (idx >= CW) ? 1'b0 : ((cnt >> idx) & 1) != 0;
    return ph ? {m_comp[3] & km, m_comp[4] & km, m_comp[5] & km}
              : {m_comp[0] & km, m_comp[1] & km, m_comp[2] & km};
  endfunction

  task automatic probe(string req, int h, int v, bit act, logic [47:0] vid);
    @(negedge clk);
    hcount = h[CW-1:0]; vcount = v[CW-1:0]; active = act; video_in = vid;
    @(negedge clk);
    check(req, pix_out, expect_pix(h, v, act, vid));
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) m_comp[i] = (i < 3) ? 16'hFFC0 : 16'h0000;
    m_pend = '0; m_en = 0; m_horiz = 0; m_depth = 1; m_hres = 0; m_vres = 0;
    repeat (3) @(negedge clk);
    // R1: output cleared during reset
    check("R1 reset output", pix_out, '0);
    rst_n = 1'b1;
    // R1/R9: reset leaves pattern off, video passes
    probe("R1 R9 off after reset", 0, 0, 1, 48'h123456789ABC);
    // R1: default depth 8, colours white/black
    set_ctrl(1, 0, 1, 0, 0);
    check("R1 default white", expect_pix(0, 0, 1, 0), 48'hFF00FF00FF00);
    probe("R1 colour0 white", 0, 0, 1, 0);
    probe("R1 colour1 black", 1, 0, 1, 0);
    // R2: first write after reset lands nowhere
    set_ctrl(1, 0, 2, 0, 0);
    put_col(6'b000001, 16'h0000);
    probe("R2 first write stores nothing", 0, 0, 1, 0);
    // R2/R3: seven-write load with distinct values
    put_col(6'b000010, 16'h8040);
    put_col(6'b000100, 16'h4080);
    put_col(6'b001000, 16'hC0C0);
    put_col(6'b010000, 16'h2100);
    put_col(6'b100000, 16'h1FC0);
    put_col(6'b100000, 16'hF000);
    check("R3 model R0", {32'h0, m_comp[0]}, 48'h8040);
    probe("R2 R3 colour0 channels", 0, 0, 1, 0);
    probe("R2 R3 colour1 channels", 1, 0, 1, 0);
    probe("R12 packing colour0", 2, 0, 1, 0);
    // R4: low data bits discarded
    put_col(6'b000001, 16'hFFFF);
    put_col(6'b000001, 16'hFFFF);
    probe("R4 low bits zero", 0, 0, 1, 0);
    // R5: each depth setting
    for (int d = 0; d < 4; d++) begin
      set_ctrl(1, 0, d, 0, 0);
      probe("R5 depth colour0", 0, 0, 1, 0);
      probe("R5 depth colour1", 1, 0, 1, 0);
    end
    // R6: vertical stripe sweep
    for (int r = 0; r < 4; r++) begin
      set_ctrl(1, 0, 2, r, 3 - r);
      for (int h = 0; h < 40; h++) probe("R6 vertical stripes", h, 5, 1, 0);
    end
    // R7: horizontal stripe sweep
    for (int r = 0; r < 4; r++) begin
      set_ctrl(1, 1, 2, 3 - r, r);
      for (int v = 0; v < 40; v++) probe("R7 horizontal stripes", 7, v, 1, 0);
    end
    // R11: exponent at or beyond counter width
    set_ctrl(1, 0, 2, CW, 0);
    for (int h = 4090; h < 4096; h++) probe("R11 wide hres colour0", h, 0, 1, 0);
    set_ctrl(1, 1, 2, 0, 15);
    for (int v = 4090; v < 4096; v++) probe("R11 wide vres colour0", 0, v, 1, 0);
    // R8: blanking, pattern on and off
    probe("R8 blank with pattern", 1, 1, 0, 48'hFFFFFFFFFFFF);
    set_ctrl(0, 0, 2, 0, 0);
    probe("R8 blank without pattern", 1, 1, 0, 48'hFFFFFFFFFFFF);
    // R9: pass-through of odd low bits
    probe("R9 passthrough", 3, 3, 1, 48'hA5A5_0F0F_3C3D);
    probe("R9 passthrough 2", 0, 0, 1, 48'h0000_0000_003F);
    // R10: output only changes after a clock edge
    @(negedge clk);
    video_in = 48'h111111111111; active = 1'b1;
    #(PERIOD/4);
    check("R10 no change before edge", pix_out, 48'h0000_0000_003F);
    @(negedge clk);
    check("R10 change after edge", pix_out, 48'h111111111111);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule